// File: doc/BRIEF.md
# Windowed Watchdog Timer

A countdown watchdog that runs on a clock-enable tick from the oscillator, divided down by a selectable prescaler. Software arms and refreshes it with a two-write unlock pair on a refresh register: a write of 0x00, then a write of 0xFF. A refresh is accepted only while the counter lies inside a programmable window. The counter can run out, or software can refresh outside the window. Either event latches a flag in the status register and raises one response output: an interrupt request or a reset request, as chosen in the response register.

Configuration lives in a control register and a response register. Each of these takes exactly one write between reset release and the first accepted refresh. After that, both are frozen until the next reset. The register port is a plain synchronous write port with a separate combinational read address. It has no valid/ready handshake and never applies back-pressure: every write presented with `wr_en_i` high is consumed at that clock edge. The oscillator tick is a single-cycle enable in the same clock domain.

Top module: `win_wdt`

## Requirements
- R1: After reset the count and both status flags are zero, the counter is stopped, `irq_o` and `rst_req_o` are low, the control register reads 0x3303 and the response register reads 0x0000.
- R2: A refresh completes only when a refresh-register write (byte address 0) with low byte 0x00 is followed by one with low byte 0xFF, with idle cycles allowed in between. An accepted refresh loads the count with the selected initial value at that edge. The first accepted refresh also starts counting.
- R3: A 0x00 write followed by any other value, or a 0xFF write without a pending 0x00, causes no reload. Every refresh-register write other than 0x00 cancels a pending 0x00.
- R4: Control bits [1:0] select the initial count: 00 gives 0x03FF, 01 gives 0x0FFF, 10 gives 0x1FFF and 11 gives 0x3FFF.
- R5: Control bits [7:4] select the divide ratio of oscillator ticks per count step: 0000 gives /1, 0001 gives /4, 0010 gives /16, 0011 gives /32, 0100 gives /64 and 0101 gives /256. Any other code divides by 1. The prescaler restarts on an accepted refresh.
- R6: With period P equal to the initial value plus 1 and Q = P/4, a refresh is in window when count ≤ start limit and count ≥ end limit. Control bits [13:12] set the start limit: 00 gives Q-1 (25%), 01 gives 2Q-1, 10 gives 3Q-1 and 11 gives P-1 (100%). Control bits [9:8] set the end limit: 00 gives 3Q (75%), 01 gives 2Q, 10 gives Q and 11 gives 0 (0%).
- R7: A completed pair outside the window, once counting has started, sets the refresh-error flag (status bit 15) and leaves the count untouched.
- R8: A divided tick while the count is 0 sets the underflow flag (status bit 14). The count then holds at 0 and the counter stops until a reset or an accepted refresh.
- R9: The control register (address 2) and the response register (address 6) each accept only their first write, and only before the first accepted refresh. All later writes to them are ignored.
- R10: Writing 0x0000 to the status register (address 4) clears both flags. A nonzero write is ignored. A flag event in the same cycle wins over the clear.
- R11: While either flag is set, `rst_req_o` is high if response bit 7 is set, and `irq_o` is high otherwise. The two outputs are never high together.
- R12: The first refresh after reset is accepted regardless of the window setting.
- R13: Reads return the control value at address 2 (unused bits read 0). Address 4 returns {error, underflow, count[13:0]}. Address 6 returns the response bit at bit 7. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | Oscillator clock-enable tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write byte address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read byte address |
| rd_data_o | output | 16 | Combinational read data |
| irq_o | output | 1 | Interrupt request (level) |
| rst_req_o | output | 1 | Reset request (level) |

## Verification
The in-RTL assertions check on every cycle that the counter moves by at most one step, that a reload lands the selected initial value, that an underflow leaves the counter stopped at zero, that the configuration stays frozen once the block has started, that flag setting and clearing behave as specified, and that the two responses are exclusive. Other properties depend on a whole sequence of writes and elapsed time, and only the bench scenarios can show them. These are the unlock-pair rejection cases, window acceptance before and after the counter crosses the start limit, the exact divide ratio, and underflow timing. The bench covers them with a cycle-accurate reference model compared on every clock, plus named spot checks.

// File: rtl/win_wdt_pkg.sv
package win_wdt_pkg;
  // Count width is fixed by the largest period (0x3FFF); status packs {err, uf, count}.
  localparam int CNT_W  = 14;
  localparam int PRE_W  = 8;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_REFRESH = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd2;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd4;
  localparam logic [ADDR_W-1:0] A_RESP    = 3'd6;

  localparam logic [DATA_W-1:0] CTRL_MASK  = 16'h33F3;
  localparam logic [DATA_W-1:0] CTRL_RESET = 16'h3303;

  localparam logic [7:0] KEY_ARM  = 8'h00;
  localparam logic [7:0] KEY_FIRE = 8'hFF;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [CNT_W:0]   lim_t;

  function automatic cnt_t period_last(input logic [1:0] sel);
    case (sel)
      2'b00:   return cnt_t'(14'h03FF);
      2'b01:   return cnt_t'(14'h0FFF);
      2'b10:   return cnt_t'(14'h1FFF);
      default: return cnt_t'(14'h3FFF);
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] div_last(input logic [3:0] sel);
    case (sel)
      4'b0001: return 8'd3;
      4'b0010: return 8'd15;
      4'b0011: return 8'd31;
      4'b0100: return 8'd63;
      4'b0101: return 8'd255;
      default: return 8'd0;
    endcase
  endfunction

  function automatic lim_t start_limit(input logic [1:0] tsel, input logic [1:0] ssel);
    lim_t per, q, one;
    one = lim_t'(1);
    per = {1'b0, period_last(tsel)} + one;
    q   = per >> 2;
    case (ssel)
      2'b00:   return q - one;
      2'b01:   return (q << 1) - one;
      2'b10:   return (q << 1) + q - one;
      default: return per - one;
    endcase
  endfunction

  function automatic lim_t end_limit(input logic [1:0] tsel, input logic [1:0] esel);
    lim_t per, q;
    per = {1'b0, period_last(tsel)} + lim_t'(1);
    q   = per >> 2;
    case (esel)
      2'b00:   return (q << 1) + q;
      2'b01:   return q << 1;
      2'b10:   return q;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/win_wdt_presc.sv
module win_wdt_presc
  import win_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             restart,
  input  logic [PRE_W-1:0] last,
  output logic             step
);
  logic [PRE_W-1:0] acc_q;
  logic             wrap;

  assign wrap = (acc_q >= last);
  assign step = osc_tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (restart)  acc_q <= '0;
    else if (osc_tick) acc_q <= wrap ? '0 : acc_q + 1'b1;
  end

  // R5: the accumulator never passes the selected wrap point while ticking.
  a_r5_presc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_tick && !restart && wrap) |=> (acc_q == '0));
endmodule

// File: rtl/win_wdt_core.sv
module win_wdt_core
  import win_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       reload,
  input  logic [1:0] tmo_sel,
  input  logic [1:0] wstart_sel,
  input  logic [1:0] wend_sel,
  output cnt_t       count,
  output logic       in_window,
  output logic       uf_evt
);
  cnt_t count_q;
  logic run_q;
  lim_t slim, elim;

  assign slim      = start_limit(tmo_sel, wstart_sel);
  assign elim      = end_limit(tmo_sel, wend_sel);
  assign in_window = ({1'b0, count_q} <= slim) && ({1'b0, count_q} >= elim);
  assign uf_evt    = run_q && step && (count_q == '0) && !reload;
  assign count     = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else if (reload) begin
      count_q <= period_last(tmo_sel);
      run_q   <= 1'b1;
    end else if (run_q && step) begin
      if (count_q == '0) run_q   <= 1'b0;
      else               count_q <= count_q - 1'b1;
    end
  end

  // R2: a reload lands the selected initial value.
  a_r2_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (count_q == period_last($past(tmo_sel))));
  // R5: without a reload the count moves by at most one step.
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ((count_q == $past(count_q)) || (count_q == $past(count_q) - 1'b1)));
  // R8: an underflow leaves the counter stopped at zero.
  a_r8_uf_stop: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (count_q == '0) && !run_q);
  // R8: a stopped counter holds until reloaded.
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reload) |=> $stable(count_q));
endmodule

// File: rtl/win_wdt_regs.sv
module win_wdt_regs
  import win_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  cnt_t              count,
  input  logic              in_window,
  input  logic              uf_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic              refresh_ok,
  output logic [1:0]        tmo_sel,
  output logic [3:0]        div_sel,
  output logic [1:0]        wstart_sel,
  output logic [1:0]        wend_sel,
  output logic              irq,
  output logic              rst_req
);
  logic [DATA_W-1:0] ctrl_q;
  logic armed_q, started_q, ctrl_done_q, resp_done_q, resp_q, uf_q, err_q;
  logic wr_ref, wr_ctrl, wr_stat, wr_resp, pair_done, refresh_bad, stat_clear, any_flag;

  assign wr_ref  = wr_en && (wr_addr == A_REFRESH);
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STATUS);
  assign wr_resp = wr_en && (wr_addr == A_RESP);

  assign pair_done   = wr_ref && armed_q && (wr_data[7:0] == KEY_FIRE);
  assign refresh_ok  = pair_done && (!started_q || in_window);
  assign refresh_bad = pair_done && started_q && !in_window;
  assign stat_clear  = wr_stat && (wr_data == '0);

  assign tmo_sel    = ctrl_q[1:0];
  assign div_sel    = ctrl_q[7:4];
  assign wend_sel   = ctrl_q[9:8];
  assign wstart_sel = ctrl_q[13:12];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      started_q   <= 1'b0;
      ctrl_done_q <= 1'b0;
      resp_done_q <= 1'b0;
      resp_q      <= 1'b0;
      ctrl_q      <= CTRL_RESET;
      uf_q        <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (wr_ref) armed_q <= (wr_data[7:0] == KEY_ARM);
      if (refresh_ok) started_q <= 1'b1;
      if (wr_ctrl && !started_q && !ctrl_done_q) begin
        ctrl_q      <= wr_data & CTRL_MASK;
        ctrl_done_q <= 1'b1;
      end
      if (wr_resp && !started_q && !resp_done_q) begin
        resp_q      <= wr_data[7];
        resp_done_q <= 1'b1;
      end
      uf_q  <= (uf_q  && !stat_clear) || uf_evt;
      err_q <= (err_q && !stat_clear) || refresh_bad;
    end
  end

  assign any_flag = uf_q || err_q;
  assign irq      = any_flag && !resp_q;
  assign rst_req  = any_flag && resp_q;

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = ctrl_q;
      A_STATUS: rd_data = {err_q, uf_q, count};
      A_RESP:   rd_data = {8'h00, resp_q, 7'h00};
      default:  rd_data = '0;
    endcase
  end

  // R9: configuration is frozen once started.
  a_r9_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |=> ($stable(ctrl_q) && $stable(resp_q)));
  // R7: an out-of-window pair sets the error flag.
  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_bad |=> err_q);
  // R10: a zero write to status with no new event clears both flags.
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clear && !refresh_bad && !uf_evt) |=> (!err_q && !uf_q));
  // R11: responses are exclusive.
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, rst_req}));
  // R2: an accepted refresh marks the block started.
  a_r2_started: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ok |=> started_q);
endmodule

// File: rtl/win_wdt.sv
module win_wdt
  import win_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  cnt_t       count;
  logic       in_window, uf_evt, refresh_ok, step;
  logic [1:0] tmo_sel, wstart_sel, wend_sel;
  logic [3:0] div_sel;

  win_wdt_regs regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .wr_data    (wr_data_i),
    .rd_addr    (rd_addr_i),
    .count      (count),
    .in_window  (in_window),
    .uf_evt     (uf_evt),
    .rd_data    (rd_data_o),
    .refresh_ok (refresh_ok),
    .tmo_sel    (tmo_sel),
    .div_sel    (div_sel),
    .wstart_sel (wstart_sel),
    .wend_sel   (wend_sel),
    .irq        (irq_o),
    .rst_req    (rst_req_o)
  );

  win_wdt_presc presc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick_i),
    .restart  (refresh_ok),
    .last     (div_last(div_sel)),
    .step     (step)
  );

  win_wdt_core core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .reload     (refresh_ok),
    .tmo_sel    (tmo_sel),
    .wstart_sel (wstart_sel),
    .wend_sel   (wend_sel),
    .count      (count),
    .in_window  (in_window),
    .uf_evt     (uf_evt)
  );
endmodule

// File: tb/win_wdt_tb_top.sv
module win_wdt_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        osc_tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = 3'd4;
  logic [15:0] rd_data_o;
  logic        irq_o, rst_req_o;

  win_wdt dut_i (.*);

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    cmp_on = 0, done = 0, tick_on = 0;

  // Reference model state
  int m_cnt, m_pre, m_ctrl;
  bit m_run, m_start, m_arm, m_cdone, m_rdone, m_rsel, m_uf, m_err;

  function automatic int m_last(int s);
    case (s) 0: return 'h3FF; 1: return 'hFFF; 2: return 'h1FFF; default: return 'h3FFF; endcase
  endfunction
  function automatic int m_div(int s);
    case (s) 1: return 4; 2: return 16; 3: return 32; 4: return 64; 5: return 256; default: return 1; endcase
  endfunction

  always @(posedge clk) begin
    #1;
    osc_tick_i = tick_on ? ~osc_tick_i : 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_ctrl = 'h3303; m_run = 0; m_start = 0; m_arm = 0;
      m_cdone = 0; m_rdone = 0; m_rsel = 0; m_uf = 0; m_err = 0;
    end else begin
      int last, q, slim, elim;
      bit ok, bad, dt, uf, inwin;
      last  = m_last(m_ctrl & 3);
      q     = (last + 1) / 4;
      slim  = q * (((m_ctrl >> 12) & 3) + 1) - 1;
      elim  = q * (3 - ((m_ctrl >> 8) & 3));
      inwin = (m_cnt <= slim) && (m_cnt >= elim);
      ok = 0; bad = 0; dt = 0;
      if (wr_en_i && wr_addr_i == 0) begin
        if (wr_data_i[7:0] == 8'h00) m_arm = 1;
        else begin
          if (wr_data_i[7:0] == 8'hFF && m_arm) begin
            if (!m_start || inwin) ok = 1; else bad = 1;
          end
          m_arm = 0;
        end
      end
      if (osc_tick_i) begin
        if (m_pre >= m_div((m_ctrl >> 4) & 15) - 1) begin dt = 1; m_pre = 0; end
        else m_pre++;
      end
      uf = m_run && dt && m_cnt == 0 && !ok;
      if (ok) begin m_cnt = last; m_run = 1; m_pre = 0; end
      else if (m_run && dt) begin
        if (m_cnt == 0) m_run = 0; else m_cnt--;
      end
      if (wr_en_i && wr_addr_i == 2 && !m_start && !m_cdone) begin m_ctrl = wr_data_i & 'h33F3; m_cdone = 1; end
      if (wr_en_i && wr_addr_i == 6 && !m_start && !m_rdone) begin m_rsel = wr_data_i[7]; m_rdone = 1; end
      if (wr_en_i && wr_addr_i == 4 && wr_data_i == 0) begin m_uf = 0; m_err = 0; end
      if (uf) m_uf = 1;
      if (bad) m_err = 1;
      if (ok) m_start = 1;
    end
  end

  function automatic int m_read(int a);
    case (a)
      2: return m_ctrl;
      4: return (int'(m_err) << 15) | (int'(m_uf) << 14) | m_cnt;
      6: return int'(m_rsel) << 7;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      int er; bit ei, erq;
      er  = m_read(rd_addr_i);
      ei  = (m_uf || m_err) && !m_rsel;
      erq = (m_uf || m_err) && m_rsel;
      n_cmp++;
      if (rd_data_o !== 16'(er) || irq_o !== ei || rst_req_o !== erq) begin
        n_bad++;
        $display("FAIL %s compare @%0t: rd/irq/rst actual %h/%b/%b expected %h/%b/%b",
                 cur_req, $time, rd_data_o, irq_o, rst_req_o, 16'(er), ei, erq);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic look(input logic [2:0] a, output logic [15:0] v);
    rd_addr_i = a;
    @(negedge clk);
    v = rd_data_o;
  endtask

  task automatic refresh();
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h00FF);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    @(posedge clk); #1;
    cmp_on = 1;
    @(posedge clk); #1 rst_n = 1'b1;

    cur_req = "R1";
    look(3'd4, v); chk("R1 status", v, 0);
    chk("R1 irq", irq_o, 0); chk("R1 rst_req", rst_req_o, 0);
    look(3'd2, v); chk("R1 ctrl", v, 'h3303);
    look(3'd6, v); chk("R1 resp", v, 0);
    cur_req = "R13";
    look(3'd0, v); chk("R13 refresh addr", v, 0);
    look(3'd1, v); chk("R13 odd addr", v, 0);

    cur_req = "R9";
    wr(3'd2, 16'hFFF0);
    wr(3'd2, 16'h0003);
    look(3'd2, v); chk("R9 first ctrl write only", v, 'h33F0);
    wr(3'd6, 16'h0000);

    cur_req = "R3";
    tick_on = 1;
    wr(3'd0, 16'h0000); wr(3'd0, 16'h0012); wr(3'd0, 16'h00FF);
    look(3'd4, v); chk("R3 broken pair", v, 0);
    wr(3'd0, 16'h00FF);
    look(3'd4, v); chk("R3 lone fire", v, 0);

    cur_req = "R2";
    refresh();
    look(3'd4, v); chk("R2 load 0x3FF", v, 'h3FF);
    idle(20);
    look(3'd4, v); chk("R5 reserved div code steps /1", (v >= 'h3FF - 12 && v <= 'h3FF - 9), 1);

    cur_req = "R9";
    wr(3'd2, 16'h0003); wr(3'd6, 16'h0080);
    look(3'd2, v); chk("R9 ctrl locked", v, 'h33F0);
    look(3'd6, v); chk("R9 resp locked", v, 0);

    cur_req = "R8";
    rd_addr_i = 3'd4;
    for (int i = 0; i < 4000 && !irq_o; i++) @(negedge clk);
    look(3'd4, v); chk("R8 uf flag and zero", v, 'h4000);
    chk("R11 irq on uf", irq_o, 1);
    idle(10);
    look(3'd4, v); chk("R8 holds at zero", v, 'h4000);

    cur_req = "R10";
    wr(3'd4, 16'h1234);
    look(3'd4, v); chk("R10 nonzero ignored", v, 'h4000);
    wr(3'd4, 16'h0000);
    look(3'd4, v); chk("R10 clear", v, 0);
    chk("R10 irq low", irq_o, 0);

    cur_req = "R8";
    refresh();
    look(3'd4, v); chk("R8 resume by refresh", v, 'h3FF);

    cur_req = "R12";
    do_reset();
    wr(3'd2, 16'h0001); wr(3'd6, 16'h0080);
    refresh();
    look(3'd4, v); chk("R12 first refresh in empty window", v, 'hFFF);
    chk("R4 code 01", v, 'hFFF);
    cur_req = "R7";
    refresh();
    look(3'd4, v); chk("R7 err flag set, no reload", (v[15] == 1'b1 && v[13:0] < 14'hFFF), 1);
    chk("R11 rst_req on err", rst_req_o, 1);
    chk("R11 irq low", irq_o, 0);

    cur_req = "R4";
    do_reset(); wr(3'd2, 16'h0002); refresh();
    look(3'd4, v); chk("R4 code 10", v, 'h1FFF);
    do_reset(); wr(3'd2, 16'h0003); refresh();
    look(3'd4, v); chk("R4 code 11", v, 'h3FFF);

    cur_req = "R6";
    do_reset();
    wr(3'd2, 16'h2210);
    refresh();
    look(3'd4, v); chk("R6 first load", v, 'h3FF);
    refresh();
    look(3'd4, v); chk("R6 early refresh rejected", v[15], 1);
    wr(3'd4, 16'h0000);
    rd_addr_i = 3'd4;
    for (int i = 0; i < 4000 && rd_data_o[13:0] > 14'h2FF; i++) @(negedge clk);
    refresh();
    look(3'd4, v); chk("R6 in-window refresh accepted", v, 'h3FF);
    cur_req = "R5";
    idle(40);
    look(3'd4, v); chk("R5 /4 rate", (v >= 'h3FF - 6 && v <= 'h3FF - 4), 1);

    tick_on = 0;
    idle(4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule